// File: doc/BRIEF.md
# Supervisor Control-Register and Trap Unit

This block keeps a small set of supervisor and machine control registers for a 64-bit RISC-V hart. It carries out the system-class instructions that an upstream decoder hands it. An environment call saves the PC and cause and jumps to the trap vector. A machine return and a supervisor return jump back to their saved exception PCs. A virtual-memory fence is accepted with no effect. The two register forms of CSR access, read-and-write and read-and-set, are also executed here.

The decoder supplies the function fields, the destination index, the first source value, the 12-bit CSR address and the current PC, and pulses `exec_valid` for one cycle per instruction. All results are registered and appear for exactly one cycle on the following cycle. These results are the destination write, the PC redirect and the illegal flag. The page-table base and the translation-enable level are continuous outputs taken from the stored address-translation register.

Top module: `sys_csr_unit`

## Requirements
- R1: After reset every stored register (trap vector, scratch, supervisor exception PC, cause, machine exception PC, page-table base) is zero, `xlate_en` is 0, and `rd_we`, `redir_valid` and `illegal` are 0.
- R2: An instruction with funct3=0 and funct7=0 (environment call) stores `pc` as the supervisor exception PC and sets the cause register to 8. On the next cycle it redirects to the trap vector with bits 1:0 cleared, and it does not write rd.
- R3: funct3=0 with funct7=24 redirects to the machine exception PC. funct3=0 with funct7=8 redirects to the supervisor exception PC. Neither writes rd.
- R4: funct3=0 with funct7=9 (fence) gives no redirect, no rd write and no illegal flag. Any other funct7 with funct3=0 raises `illegal`.
- R5: funct3=1 (read-and-write) returns the old CSR value on `rd_wdata` with `rd_we`=1 and `rd_idx_o`=`rd_idx`, and stores `rs1_val` into the CSR.
- R6: funct3=2 (read-and-set) returns the old value and stores the old value ORed with `rs1_val`. funct3 values 3 to 7 raise `illegal`.
- R7: The stored CSRs are at addresses 0x105 (trap vector), 0x140 (scratch), 0x141 (supervisor exception PC), 0x142 (cause), 0x180 (address translation) and 0x341 (machine exception PC).
- R8: Addresses 0x100, 0x104, 0x14D, 0x300, 0x302, 0x303, 0x304, 0x306, 0x30A, 0x3A0, 0x3B0, 0xC01 and 0xF14 read as zero. Writes to them are dropped without raising `illegal`.
- R9: A CSR access to any other address raises `illegal`. It does not write rd and changes no CSR.
- R10: A write to 0x180 with bits 63:60 equal to 8 sets the page-table base to the value shifted left by 12. A write of zero clears the base. Any other value raises `illegal` and leaves the base unchanged. `xlate_en` is 1 exactly when the base is nonzero.
- R11: A read of 0x180 returns the base shifted right by 12, with 8 in bits 63:60 when the base is nonzero, and returns zero otherwise.
- R12: With `exec_valid` low, no CSR changes and `rd_we`, `redir_valid` and `illegal` are 0 on the next cycle. Each result lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | One-cycle strobe: execute the presented instruction |
| funct3 | input | 3 | Decoded funct3 field |
| funct7 | input | 7 | Decoded funct7 field |
| rd_idx | input | 5 | Destination register index |
| rs1_val | input | 64 | Value of the first source register |
| csr_addr | input | 12 | CSR address |
| pc | input | 64 | PC of the instruction |
| rd_we | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination index for the write |
| rd_wdata | output | 64 | Value to write to the destination |
| redir_valid | output | 1 | PC redirect request |
| redir_pc | output | 64 | Redirect target |
| illegal | output | 1 | Illegal-instruction indication |
| pt_base | output | 64 | Current page-table physical base |
| xlate_en | output | 1 | Address translation enabled |

## Verification
Every instruction result is due on the cycle after its `exec_valid` cycle. That covers `rd_we`, `rd_wdata`, `redir_valid`, `redir_pc` and `illegal`. A new `pt_base`/`xlate_en` value appears at that same edge. The bench drives each instruction at a falling edge and compares every output at the next falling edge, once exactly one rising edge has registered the result. It then drops `exec_valid` for one idle cycle. CSR contents are observed only by reading them back through later instructions. The quiet-cycle and pulse-width checks sample the cycle after an idle strobe.

// File: rtl/sys_csr_pkg.sv
package sys_csr_pkg;

    localparam int CSR_AW = 12;

    localparam logic [CSR_AW-1:0] ADDR_TVEC    = 12'h105;
    localparam logic [CSR_AW-1:0] ADDR_SCRATCH = 12'h140;
    localparam logic [CSR_AW-1:0] ADDR_SEPC    = 12'h141;
    localparam logic [CSR_AW-1:0] ADDR_CAUSE   = 12'h142;
    localparam logic [CSR_AW-1:0] ADDR_XLATE   = 12'h180;
    localparam logic [CSR_AW-1:0] ADDR_MEPC    = 12'h341;

    localparam int N_ZERO = 13;
    localparam logic [N_ZERO-1:0][CSR_AW-1:0] ZERO_ADDRS = {
        12'hF14, 12'hC01, 12'h3B0, 12'h3A0, 12'h30A, 12'h306, 12'h304,
        12'h303, 12'h302, 12'h300, 12'h14D, 12'h104, 12'h100
    };

    localparam logic [2:0] F3_PRIV = 3'd0;
    localparam logic [2:0] F3_RW   = 3'd1;
    localparam logic [2:0] F3_RS   = 3'd2;

    localparam logic [6:0] F7_ECALL  = 7'd0;
    localparam logic [6:0] F7_SRET   = 7'd8;
    localparam logic [6:0] F7_FENCE  = 7'd9;
    localparam logic [6:0] F7_MRET   = 7'd24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_TVEC,
        SEL_SCRATCH,
        SEL_SEPC,
        SEL_CAUSE,
        SEL_XLATE,
        SEL_MEPC
    } csr_sel_e;

endpackage

// File: rtl/sys_csr_decode.sv
module sys_csr_decode
    import sys_csr_pkg::*;
(
    input  logic [CSR_AW-1:0] addr,
    output csr_sel_e          sel
);

    logic [N_ZERO-1:0] zero_hit;

    for (genvar i = 0; i < N_ZERO; i++) begin : g_zero
        assign zero_hit[i] = (addr == ZERO_ADDRS[i]);
    end

    always_comb begin
        case (addr)
            ADDR_TVEC:    sel = SEL_TVEC;
            ADDR_SCRATCH: sel = SEL_SCRATCH;
            ADDR_SEPC:    sel = SEL_SEPC;
            ADDR_CAUSE:   sel = SEL_CAUSE;
            ADDR_XLATE:   sel = SEL_XLATE;
            ADDR_MEPC:    sel = SEL_MEPC;
            default:      sel = (|zero_hit) ? SEL_ZERO : SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sys_csr_xlate_codec.sv
module sys_csr_xlate_codec #(
    parameter int XLEN     = 64,
    parameter int PT_SHIFT = 12,
    parameter int MODE_W   = 4,
    parameter int MODE_VAL = 8
) (
    input  logic [XLEN-1:0] base_q,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] rd_val,
    output logic            wr_ok,
    output logic [XLEN-1:0] wr_base
);

    localparam logic [MODE_W-1:0] MODE = MODE_W'(MODE_VAL);

    logic wr_zero;
    logic mode_hit;

    assign wr_zero  = (wr_val == '0);
    assign mode_hit = (wr_val[XLEN-1 -: MODE_W] == MODE);
    assign wr_ok    = wr_zero || mode_hit;
    assign wr_base  = wr_zero ? '0 : (wr_val << PT_SHIFT);

    always_comb begin
        rd_val = base_q >> PT_SHIFT;
        if (base_q != '0) begin
            rd_val[XLEN-1 -: MODE_W] = MODE;
        end
    end

endmodule

// File: rtl/sys_csr_unit.sv
module sys_csr_unit
    import sys_csr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int PT_SHIFT    = 12,
    parameter int CAUSE_ECALL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_valid,
    input  logic [2:0]        funct3,
    input  logic [6:0]        funct7,
    input  logic [4:0]        rd_idx,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   pc,
    output logic              rd_we,
    output logic [4:0]        rd_idx_o,
    output logic [XLEN-1:0]   rd_wdata,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic              illegal,
    output logic [XLEN-1:0]   pt_base,
    output logic              xlate_en
);

    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-2){1'b1}}, 2'b00};
    localparam logic [XLEN-1:0] CAUSE_VAL  = XLEN'(CAUSE_ECALL);

    typedef struct packed {
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] ptbase;
    } csr_state_t;

    typedef struct packed {
        logic            we;
        logic [4:0]      rd;
        logic [XLEN-1:0] wdata;
        logic            redir;
        logic [XLEN-1:0] rpc;
        logic            ill;
    } result_t;

    typedef struct packed {
        csr_state_t st;
        result_t    res;
    } unit_reg_t;

    unit_reg_t r_d, r_q;

    csr_sel_e        sel;
    logic [XLEN-1:0] xlate_rd;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic            xlate_ok;
    logic [XLEN-1:0] xlate_base;

    sys_csr_decode u_decode (
        .addr (csr_addr),
        .sel  (sel)
    );

    sys_csr_xlate_codec #(
        .XLEN     (XLEN),
        .PT_SHIFT (PT_SHIFT)
    ) u_xlate (
        .base_q  (r_q.st.ptbase),
        .wr_val  (new_val),
        .rd_val  (xlate_rd),
        .wr_ok   (xlate_ok),
        .wr_base (xlate_base)
    );

    always_comb begin
        case (sel)
            SEL_TVEC:    old_val = r_q.st.tvec;
            SEL_SCRATCH: old_val = r_q.st.scratch;
            SEL_SEPC:    old_val = r_q.st.sepc;
            SEL_CAUSE:   old_val = r_q.st.cause;
            SEL_XLATE:   old_val = xlate_rd;
            SEL_MEPC:    old_val = r_q.st.mepc;
            default:     old_val = '0;
        endcase
        new_val = (funct3 == F3_RW) ? rs1_val : (old_val | rs1_val);
    end

    always_comb begin
        r_d        = r_q;
        r_d.res    = '0;
        r_d.res.rd = rd_idx;
        if (exec_valid) begin
            case (funct3)
                F3_PRIV: begin
                    case (funct7)
                        F7_ECALL: begin
                            r_d.st.sepc   = pc;
                            r_d.st.cause  = CAUSE_VAL;
                            r_d.res.redir = 1'b1;
                            r_d.res.rpc   = r_q.st.tvec & ALIGN_MASK;
                        end
                        F7_MRET: begin
                            r_d.res.redir = 1'b1;
                            r_d.res.rpc   = r_q.st.mepc;
                        end
                        F7_SRET: begin
                            r_d.res.redir = 1'b1;
                            r_d.res.rpc   = r_q.st.sepc;
                        end
                        F7_FENCE: ;
                        default:  r_d.res.ill = 1'b1;
                    endcase
                end
                F3_RW, F3_RS: begin
                    if (sel == SEL_NONE || (sel == SEL_XLATE && !xlate_ok)) begin
                        r_d.res.ill = 1'b1;
                    end else begin
                        r_d.res.we    = 1'b1;
                        r_d.res.wdata = old_val;
                        case (sel)
                            SEL_TVEC:    r_d.st.tvec    = new_val;
                            SEL_SCRATCH: r_d.st.scratch = new_val;
                            SEL_SEPC:    r_d.st.sepc    = new_val;
                            SEL_CAUSE:   r_d.st.cause   = new_val;
                            SEL_XLATE:   r_d.st.ptbase  = xlate_base;
                            SEL_MEPC:    r_d.st.mepc    = new_val;
                            default: ;
                        endcase
                    end
                end
                default: r_d.res.ill = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_we       = r_q.res.we;
    assign rd_idx_o    = r_q.res.rd;
    assign rd_wdata    = r_q.res.wdata;
    assign redir_valid = r_q.res.redir;
    assign redir_pc    = r_q.res.rpc;
    assign illegal     = r_q.res.ill;
    assign pt_base     = r_q.st.ptbase;
    assign xlate_en    = (r_q.st.ptbase != '0);

endmodule

// File: rtl/sys_csr_unit_chk.sv
module sys_csr_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_valid,
    input logic [2:0]      funct3,
    input logic [6:0]      funct7,
    input logic [XLEN-1:0] rs1_val,
    input logic [11:0]     csr_addr,
    input logic            rd_we,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic            illegal,
    input logic [XLEN-1:0] pt_base
);

    logic is_csr_op;
    assign is_csr_op = exec_valid && (funct3 == 3'd1 || funct3 == 3'd2);

    a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> (!rd_we && !redir_valid && !illegal));

    a_r9_illegal_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !redir_valid));

    a_r2_trap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && funct3 == 3'd0 && funct7 == 7'd0)
        |=> (redir_valid && redir_pc[1:0] == 2'b00 && !rd_we && !illegal));

    a_r4_fence_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && funct3 == 3'd0 && funct7 == 7'd9)
        |=> (!rd_we && !redir_valid && !illegal));

    a_r6_bad_f3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && funct3 > 3'd2) |=> (illegal && !rd_we));

    a_r10_base_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_csr_op && csr_addr == 12'h180) |=> $stable(pt_base));

    a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && funct3 == 3'd1 && csr_addr == 12'h180 &&
         rs1_val[XLEN-1 -: 4] != 4'd8 && rs1_val != '0)
        |=> (illegal && $stable(pt_base)));

endmodule

bind sys_csr_unit sys_csr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_valid  (exec_valid),
    .funct3      (funct3),
    .funct7      (funct7),
    .rs1_val     (rs1_val),
    .csr_addr    (csr_addr),
    .rd_we       (rd_we),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .illegal     (illegal),
    .pt_base     (pt_base)
);

// File: tb/sys_csr_unit_tb.sv
module sys_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_valid = 1'b0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rs1_val = '0;
    logic [11:0] csr_addr = '0;
    logic [63:0] pc = '0;
    logic        rd_we;
    logic [4:0]  rd_idx_o;
    logic [63:0] rd_wdata;
    logic        redir_valid;
    logic [63:0] redir_pc;
    logic        illegal;
    logic [63:0] pt_base;
    logic        xlate_en;

    int n_checks = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sys_csr_unit u_dut (
        .clk (clk), .rst_n (rst_n), .exec_valid (exec_valid),
        .funct3 (funct3), .funct7 (funct7), .rd_idx (rd_idx),
        .rs1_val (rs1_val), .csr_addr (csr_addr), .pc (pc),
        .rd_we (rd_we), .rd_idx_o (rd_idx_o), .rd_wdata (rd_wdata),
        .redir_valid (redir_valid), .redir_pc (redir_pc),
        .illegal (illegal), .pt_base (pt_base), .xlate_en (xlate_en)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  f3;
        logic [6:0]  f7;
        logic [11:0] addr;
        logic [63:0] rs1;
        logic [63:0] ipc;
        logic        e_we;
        logic [63:0] e_data;
        logic        e_redir;
        logic [63:0] e_pc;
        logic        e_ill;
        logic [63:0] e_pt;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R5 R7: write trap vector
        '{8'd5,  3'd1, 7'd0,  12'h105, 64'h0000_0000_8000_0103, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R6: set bits in trap vector
        '{8'd6,  3'd2, 7'd0,  12'h105, 64'h10, 64'h0, 1'b1, 64'h0000_0000_8000_0103, 1'b0, 64'h0, 1'b0, 64'h0},
        // R2: environment call, target aligned
        '{8'd2,  3'd0, 7'd0,  12'h000, 64'h0, 64'h1000, 1'b0, 64'h0, 1'b1, 64'h0000_0000_8000_0110, 1'b0, 64'h0},
        // R2: saved PC
        '{8'd2,  3'd2, 7'd0,  12'h141, 64'h0, 64'h0, 1'b1, 64'h1000, 1'b0, 64'h0, 1'b0, 64'h0},
        // R2: cause
        '{8'd2,  3'd2, 7'd0,  12'h142, 64'h0, 64'h0, 1'b1, 64'h8, 1'b0, 64'h0, 1'b0, 64'h0},
        // R3: supervisor return
        '{8'd3,  3'd0, 7'd8,  12'h000, 64'h0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h1000, 1'b0, 64'h0},
        // R7: machine exception PC
        '{8'd7,  3'd1, 7'd0,  12'h341, 64'h2000, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R3: machine return
        '{8'd3,  3'd0, 7'd24, 12'h000, 64'h0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h2000, 1'b0, 64'h0},
        // R5: scratch write
        '{8'd5,  3'd1, 7'd0,  12'h140, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R5: scratch swap returns old
        '{8'd5,  3'd1, 7'd0,  12'h140, 64'h5, 64'h0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 64'h0, 1'b0, 64'h0},
        // R4: fence silent
        '{8'd4,  3'd0, 7'd9,  12'h000, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R4: unknown funct7
        '{8'd4,  3'd0, 7'd5,  12'h000, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h0},
        // R6: funct3 3 illegal
        '{8'd6,  3'd3, 7'd0,  12'h140, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h0},
        // R9: illegal access left scratch untouched
        '{8'd9,  3'd2, 7'd0,  12'h140, 64'h0, 64'h0, 1'b1, 64'h5, 1'b0, 64'h0, 1'b0, 64'h0},
        // R8: write to read-zero address
        '{8'd8,  3'd1, 7'd0,  12'h300, 64'hFFFF, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R8: still zero
        '{8'd8,  3'd2, 7'd0,  12'h300, 64'h0, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R8: hart id reads zero
        '{8'd8,  3'd2, 7'd0,  12'hF14, 64'h7, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        // R9: unlisted address
        '{8'd9,  3'd2, 7'd0,  12'h123, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h0},
        // R10: enable translation
        '{8'd10, 3'd1, 7'd0,  12'h180, 64'h8000_0000_0008_0000, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0000_0000_8000_0000},
        // R11: encoded read back
        '{8'd11, 3'd2, 7'd0,  12'h180, 64'h0, 64'h0, 1'b1, 64'h8000_0000_0008_0000, 1'b0, 64'h0, 1'b0, 64'h0000_0000_8000_0000},
        // R10: bad mode rejected
        '{8'd10, 3'd1, 7'd0,  12'h180, 64'h1000_0000_0000_0001, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h0000_0000_8000_0000},
        // R11: unchanged after rejection
        '{8'd11, 3'd2, 7'd0,  12'h180, 64'h0, 64'h0, 1'b1, 64'h8000_0000_0008_0000, 1'b0, 64'h0, 1'b0, 64'h0000_0000_8000_0000},
        // R10: zero disables
        '{8'd10, 3'd1, 7'd0,  12'h180, 64'h0, 64'h0, 1'b1, 64'h8000_0000_0008_0000, 1'b0, 64'h0, 1'b0, 64'h0},
        // R11: reads zero when off
        '{8'd11, 3'd2, 7'd0,  12'h180, 64'h0, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0}
    };

    task automatic chk(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] f3, input logic [6:0] f7, input logic [11:0] a,
                         input logic [63:0] r1, input logic [63:0] ipc, input logic [4:0] rd);
        @(negedge clk);
        exec_valid = 1'b1;
        funct3 = f3; funct7 = f7; csr_addr = a; rs1_val = r1; pc = ipc; rd_idx = rd;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_bad++;
        $display("FAIL R12 watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("rd_we after reset", 1, 64'(rd_we), 64'd0);
        chk("redir after reset", 1, 64'(redir_valid), 64'd0);
        chk("illegal after reset", 1, 64'(illegal), 64'd0);
        chk("pt_base after reset", 1, pt_base, 64'd0);
        chk("xlate_en after reset", 1, 64'(xlate_en), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].f3, VECS[i].f7, VECS[i].addr, VECS[i].rs1, VECS[i].ipc, 5'(i + 1));
            chk($sformatf("v%0d rd_we", i), int'(VECS[i].req), 64'(rd_we), 64'(VECS[i].e_we));
            if (VECS[i].e_we) begin
                chk($sformatf("v%0d rd_wdata", i), int'(VECS[i].req), rd_wdata, VECS[i].e_data);
                chk($sformatf("v%0d rd_idx_o", i), 5, 64'(rd_idx_o), 64'(i + 1));
            end
            chk($sformatf("v%0d redir_valid", i), int'(VECS[i].req), 64'(redir_valid), 64'(VECS[i].e_redir));
            if (VECS[i].e_redir)
                chk($sformatf("v%0d redir_pc", i), int'(VECS[i].req), redir_pc, VECS[i].e_pc);
            chk($sformatf("v%0d illegal", i), int'(VECS[i].req), 64'(illegal), 64'(VECS[i].e_ill));
            chk($sformatf("v%0d pt_base", i), 10, pt_base, VECS[i].e_pt);
            chk($sformatf("v%0d xlate_en", i), 10, 64'(xlate_en), 64'(VECS[i].e_pt != 64'd0));
            exec_valid = 1'b0;
        end

        // R12: result lasts one cycle; idle strobe ignores presented fields
        issue(3'd0, 7'd0, 12'h000, 64'h0, 64'h3000, 5'd1);
        chk("ecall redirect", 12, 64'(redir_valid), 64'd1);
        funct3 = 3'd1; csr_addr = 12'h140; rs1_val = 64'h99;
        exec_valid = 1'b0;
        @(negedge clk);
        chk("pulse ends", 12, 64'(redir_valid), 64'd0);
        chk("idle no write", 12, 64'(rd_we), 64'd0);
        chk("idle no illegal", 12, 64'(illegal), 64'd0);
        issue(3'd2, 7'd0, 12'h140, 64'h0, 64'h0, 5'd2);
        chk("scratch kept while idle", 12, rd_wdata, 64'h5);
        exec_valid = 1'b0;
        issue(3'd2, 7'd0, 12'h141, 64'h0, 64'h0, 5'd2);
        chk("idle ecall pc saved", 2, rd_wdata, 64'h3000);
        exec_valid = 1'b0;

        // R1: reset clears stored values
        issue(3'd1, 7'd0, 12'h180, 64'h8000_0000_0000_0001, 64'h0, 5'd3);
        exec_valid = 1'b0;
        chk("base set before reset", 10, pt_base, 64'h1000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("xlate_en cleared", 1, 64'(xlate_en), 64'd0);
        rst_n = 1'b1;
        issue(3'd2, 7'd0, 12'h140, 64'h0, 64'h0, 5'd4);
        chk("scratch cleared", 1, rd_wdata, 64'd0);
        exec_valid = 1'b0;
        issue(3'd2, 7'd0, 12'h105, 64'h0, 64'h0, 5'd4);
        chk("trap vector cleared", 1, rd_wdata, 64'd0);
        exec_valid = 1'b0;

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule